// File: doc/BRIEF.md
# Processor Soft-Initialisation Pulse Generator

This block drives the processor's soft-initialisation line from a host bridge. Four independent events can request a soft reset of the processor. One is a write to the reset control register that moves its CPU-reset bit from 0 to 1 while its system-reset bit is clear. The others are a write to port 92h with bit 0 set, a shutdown special cycle decoded on the PCI bus, and a falling edge on the keyboard controller's active-low reset request. The block merges these events into one active-low open-drain output. Each event produces a low pulse of exactly a fixed number of PCI clocks, 64 by default.

The register and port writes, and the shutdown decode, arrive as single-cycle strobes from decoders outside the block. The keyboard-controller request is asynchronous. It is synchronised and edge-detected, so a request held low produces only one pulse. A trigger that arrives during a pulse restarts the full pulse length. A CPU-reset bit rising while the system-reset bit is set produces no pulse, because the hard-reset path handles that case.

Top module: `initPulseGen`

## Requirements
- R1: While reset is asserted, and from reset release until the first trigger, `initN` is 1 (released).
- R2: A cycle with `rstCtlWr`=1, `rstCtlCpu`=1 and `rstCtlSys`=0, in which the stored CPU-reset bit is 0, drives `initN` to 0 from the following cycle.
- R3: A reset-control write with `rstCtlCpu`=1 and `rstCtlSys`=1 starts no pulse. A write of `rstCtlCpu`=1 when the stored CPU-reset bit is already 1 also starts no pulse.
- R4: A cycle with `shutdownCyc`=1 drives `initN` to 0 from the following cycle.
- R5: A cycle with `p92Wr`=1 and `p92Bit0`=1 drives `initN` to 0 from the following cycle. A write with `p92Bit0`=0 has no effect.
- R6: A 1-to-0 transition of `kbcRstN` that is set up before clock edge E drives `initN` to 0 after edge E+2. Holding the input low yields a single pulse.
- R7: A single trigger holds `initN` at 0 for exactly `PULSE_LEN` cycles, after which it returns to 1.
- R8: A trigger during a pulse restarts the count, so `initN` stays 0 for `PULSE_LEN` cycles after the latest trigger.
- R9: The stored CPU-reset bit resets to 0. Every reset-control write loads it with `rstCtlCpu`, whether or not a pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rstCtlWr | input | 1 | Write strobe for the reset control register |
| rstCtlSys | input | 1 | System-reset bit value being written |
| rstCtlCpu | input | 1 | CPU-reset bit value being written |
| p92Wr | input | 1 | Write strobe for port 92h |
| p92Bit0 | input | 1 | Bit 0 of the data written to port 92h |
| shutdownCyc | input | 1 | Decoded PCI shutdown special cycle, one-cycle strobe |
| kbcRstN | input | 1 | Asynchronous active-low keyboard controller reset request |
| initN | output | 1 | Active-low soft-initialisation output, 1 means released |

## Verification
The three strobe triggers drive `initN` low from the cycle after the edge that samples them. A keyboard-controller fall takes two more edges because of the synchroniser and the edge detector. The output then stays low for exactly `PULSE_LEN` cycles after the most recent trigger. The bench applies every input at a falling edge. After each rising edge it advances a reference model that keeps its own four-deep history of the keyboard input. It compares `initN` at the next falling edge, so every expected value carries the same register count as the design.

// File: rtl/initPkg.sv
package initPkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic loadCnt;    // restart the pulse counter at full length
    logic captureCpu; // store the CPU-reset bit being written
  } ctlStrobes_t;
endpackage

// File: rtl/initDatapath.sv
module initDatapath
  import initPkg::*;
#(
  parameter int PULSE_LEN   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        cpuBitIn,
  input  logic        kbcRstN,
  output logic        kbcFall,
  output logic        cpuBitQ,
  output logic        pulseActive
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  // Synchroniser chain plus one extra stage used for edge detection.
  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0]     cnt;

  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= 1'b1;
        else if (gi == 0) syncQ[gi] <= kbcRstN;
        else syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign kbcFall = syncQ[SYNC_STAGES] & ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuBitQ <= 1'b0;
    else if (strobes.captureCpu) cpuBitQ <= cpuBitIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobes.loadCnt) cnt <= LOAD_VAL;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign pulseActive = (cnt != '0);
endmodule

// File: rtl/initControl.sv
module initControl
  import initPkg::*;
(
  input  logic        rstCtlWr,
  input  logic        rstCtlSys,
  input  logic        rstCtlCpu,
  input  logic        p92Wr,
  input  logic        p92Bit0,
  input  logic        shutdownCyc,
  input  logic        kbcFall,
  input  logic        cpuBitQ,
  output ctlStrobes_t strobes
);
  logic cpuRise;
  logic p92Hit;

  always_comb begin
    cpuRise = rstCtlWr & rstCtlCpu & ~cpuBitQ & ~rstCtlSys;
    p92Hit  = p92Wr & p92Bit0;
    strobes.loadCnt    = cpuRise | p92Hit | shutdownCyc | kbcFall;
    strobes.captureCpu = rstCtlWr;
  end
endmodule

// File: rtl/initPulseGen.sv
module initPulseGen
  import initPkg::*;
#(
  parameter int PULSE_LEN   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rstCtlWr,
  input  logic rstCtlSys,
  input  logic rstCtlCpu,
  input  logic p92Wr,
  input  logic p92Bit0,
  input  logic shutdownCyc,
  input  logic kbcRstN,
  output logic initN
);
  ctlStrobes_t strobes;
  logic kbcFall;
  logic cpuBitQ;
  logic pulseActive;

  initControl u_ctl (
    .rstCtlWr    (rstCtlWr),
    .rstCtlSys   (rstCtlSys),
    .rstCtlCpu   (rstCtlCpu),
    .p92Wr       (p92Wr),
    .p92Bit0     (p92Bit0),
    .shutdownCyc (shutdownCyc),
    .kbcFall     (kbcFall),
    .cpuBitQ     (cpuBitQ),
    .strobes     (strobes)
  );

  initDatapath #(.PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cpuBitIn    (rstCtlCpu),
    .kbcRstN     (kbcRstN),
    .kbcFall     (kbcFall),
    .cpuBitQ     (cpuBitQ),
    .pulseActive (pulseActive)
  );

  // Open-drain style: 0 pulls low, 1 releases.
  assign initN = ~pulseActive;
endmodule

// File: rtl/initPulseGenChecker.sv
module initPulseGenChecker #(
  parameter int PULSE_LEN = 64
) (
  input logic clk,
  input logic rstN,
  input logic rstCtlWr,
  input logic rstCtlSys,
  input logic rstCtlCpu,
  input logic p92Wr,
  input logic p92Bit0,
  input logic shutdownCyc,
  input logic initN
);
  // Shadow of the stored CPU-reset bit, kept from the ports alone.
  logic shadowCpu;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowCpu <= 1'b0;
    else if (rstCtlWr) shadowCpu <= rstCtlCpu;
  end

  assert_reset_release_R1: assert property (@(posedge clk) !rstN |=> initN);

  assert_cpu_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rstCtlWr && rstCtlCpu && !rstCtlSys && !shadowCpu) |=> !initN);

  assert_shutdown_R4: assert property (@(posedge clk) disable iff (!rstN)
    shutdownCyc |=> !initN);

  assert_p92_R5: assert property (@(posedge clk) disable iff (!rstN)
    (p92Wr && p92Bit0) |=> !initN);
endmodule

bind initPulseGen initPulseGenChecker #(.PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/tb_initPulseGen.sv
`timescale 1ns/1ps
module tb_initPulseGen;
  localparam int PULSE_LEN = 64;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rstCtlWr = 0, rstCtlSys = 0, rstCtlCpu = 0;
  logic p92Wr = 0, p92Bit0 = 0, shutdownCyc = 0, kbcRstN = 1;
  logic initN;

  int checks = 0;
  int failures = 0;

  // Reference model state.
  int   mCnt = 0;
  logic mCpu = 1'b0;
  logic [3:0] kh = 4'hF; // kh[0]: value set up before the coming edge

  always #2.5 clk = ~clk;

  initPulseGen #(.PULSE_LEN(PULSE_LEN), .SYNC_STAGES(SYNC_STAGES)) dut (.*);

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: initN actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic trigNow();
    logic cpuRise;
    cpuRise = rstCtlWr && rstCtlCpu && !rstCtlSys && !mCpu;
    return cpuRise || (p92Wr && p92Bit0) || shutdownCyc || (kh[3] && !kh[2]);
  endfunction

  // Inputs already set at a falling edge; advance one clock and compare.
  task automatic step(input string tag);
    logic t;
    kh = {kh[2:0], kbcRstN};
    t = trigNow();
    @(posedge clk);
    if (t) mCnt = PULSE_LEN;
    else if (mCnt > 0) mCnt--;
    if (rstCtlWr) mCpu = rstCtlCpu;
    @(negedge clk);
    check(initN, (mCnt == 0), tag);
  endtask

  task automatic idle();
    rstCtlWr = 0; rstCtlSys = 0; rstCtlCpu = 0;
    p92Wr = 0; p92Bit0 = 0; shutdownCyc = 0;
  endtask

  task automatic idleSteps(input int n, input string tag);
    idle();
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lowCount;
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(initN, 1'b1, "R1 during reset");
    rstN = 1'b1;
    idleSteps(5, "R1 after release");

    // R2 and R7: CPU-reset rise with system bit clear, exact length
    rstCtlWr = 1; rstCtlCpu = 1; rstCtlSys = 0;
    step("R2 cpu rise");
    idle();
    lowCount = 1;
    while (initN == 1'b0 && lowCount < 200) begin step("R7 pulse length"); if (!initN) lowCount++; end
    checks++;
    if (lowCount != PULSE_LEN) begin
      failures++;
      $display("FAIL R7: low cycles actual=%0d expected=%0d", lowCount, PULSE_LEN);
    end

    // R3 and R9: stored bit is 1, second write of 1 gives no pulse
    rstCtlWr = 1; rstCtlCpu = 1; rstCtlSys = 0; step("R9 already set");
    idleSteps(3, "R3 no pulse when stored bit set");
    rstCtlWr = 1; rstCtlCpu = 0; step("R9 clear bit");
    rstCtlWr = 1; rstCtlCpu = 1; rstCtlSys = 1; step("R3 system bit blocks");
    idleSteps(3, "R3 no pulse");
    rstCtlWr = 1; rstCtlCpu = 0; rstCtlSys = 0; step("R9 clear again");
    rstCtlWr = 1; rstCtlCpu = 1; step("R9 rise after clear");
    idleSteps(PULSE_LEN + 2, "R7 drain");

    // R5: port 92h bit 0 clear has no effect, set triggers
    p92Wr = 1; p92Bit0 = 0; step("R5 bit0 clear");
    idleSteps(2, "R5 no pulse");
    p92Wr = 1; p92Bit0 = 1; step("R5 bit0 set");
    // R8: retrigger mid-pulse via shutdown (R4)
    idleSteps(30, "R8 first half");
    shutdownCyc = 1; step("R4 shutdown retrigger");
    idleSteps(PULSE_LEN + 3, "R8 restarted length");

    // R6: held-low keyboard request yields one pulse
    kbcRstN = 0;
    idleSteps(3 * PULSE_LEN, "R6 held low single pulse");
    kbcRstN = 1;
    idleSteps(4, "R6 release");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      idle();
      rstCtlWr    = ($urandom_range(0, 39) == 0);
      rstCtlCpu   = $urandom_range(0, 1);
      rstCtlSys   = ($urandom_range(0, 3) == 0);
      p92Wr       = ($urandom_range(0, 79) == 0);
      p92Bit0     = $urandom_range(0, 1);
      shutdownCyc = ($urandom_range(0, 149) == 0);
      if ($urandom_range(0, 59) == 0) kbcRstN = ~kbcRstN;
      step("R8 random mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule